// File: doc/BRIEF.md
# Transmit-Empty Interrupt Qualifier

This block decides when a FIFO-based UART transmitter raises its holding-register-empty interrupt. It watches the transmit FIFO fill level, strobes for writes to the holding register, and strobes for reads of the interrupt identification register together with the identification code the priority logic is presenting. A per-bit tick from the baud generator and the frame settings (data length, parity) let it measure one character time less the stop bit.

The block keeps a usage history. If the FIFO held at least two characters at once since the last empty event, the next drain to empty raises the interrupt on the following clock. If the FIFO was only lightly used, the interrupt is held back by start bit plus data bits plus parity bit times. This gives start-up software room to fill the FIFO without servicing an interrupt per byte. A holding-register write clears the interrupt and aborts a pending delay. A read of the identification register clears it only when the code shows this source on top.

Top module: `thre_irq_qual`

## Requirements
- R1: After reset the interrupt output is low, the usage history is clear and no delay is running.
- R2: When the FIFO level reaches 0 from a nonzero value and the level has been 2 or more at some cycle since the previous empty event, the interrupt is high on the clock edge after the level is first seen as 0.
- R3: When the level reaches 0 without such history, the interrupt stays low until N bit ticks have been seen and rises on the edge that samples the N-th tick, where N = 1 + D + P, D = 5 + word_len_i (word_len_i 0..3 gives 5..8 data bits) and P = parity_en_i.
- R4: The interrupt only rises while the FIFO level is 0.
- R5: A holding-register write (thr_wr_i high for a cycle) drives the interrupt low on the next edge.
- R6: An identification-register read clears the interrupt on the next edge only when iir_id_i equals 3'b001; with any other code the interrupt is unchanged.
- R7: A holding-register write while the delay is running cancels it; no interrupt follows, however many ticks arrive later.
- R8: The usage history is cleared at each empty event, so a drain after light use that follows a drain after heavy use is delayed again.
- R9: When a write and an empty event fall in the same cycle, the write wins and the interrupt stays low.
- R10: Once high, the interrupt stays high until a write or a qualifying identification read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_level_i | input | LVL_W (5) | Transmit FIFO fill level |
| thr_wr_i | input | 1 | Holding-register write strobe |
| iir_rd_i | input | 1 | Identification-register read strobe |
| iir_id_i | input | 3 | Identification code shown on the read (bits 3:1) |
| word_len_i | input | WLEN_W (2) | Data length code, 0..3 for 5..8 bits |
| parity_en_i | input | 1 | Parity bit present in the frame |
| bit_tick_i | input | 1 | One pulse per bit time |
| thre_irq_o | output | 1 | Holding-register-empty interrupt |

## Verification
A history flag stuck low turns the immediate interrupt of a heavy drain into a delayed one, so the output is low one edge after the drain where high was due. A stuck-high flag makes a light drain fire at once, which shows on the same edge. A wrong load value in the character timer moves the rising edge by whole ticks, and the bench catches it by sampling both after N-1 ticks and after N. A missed cancel or a wrong identification decode shows as a stray high level within a few ticks or cycles of the offending strobe.

// File: rtl/thre_qual_pkg.sv
package thre_qual_pkg;
  localparam logic [2:0] IID_THRE = 3'b001;

  typedef enum logic {
    TMR_IDLE = 1'b0,
    TMR_RUN  = 1'b1
  } tmr_state_e;
endpackage

// File: rtl/thre_fifo_hist.sv
module thre_fifo_hist #(
  parameter int unsigned LVL_W     = 5,
  parameter int unsigned HEAVY_LVL = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] fifo_level_i,
  output logic             empty_evt_o,
  output logic             hist_o
);
  localparam logic [LVL_W-1:0] HeavyLvl = LVL_W'(HEAVY_LVL);

  logic empty_q, hist_q, empty_now;

  assign empty_now   = (fifo_level_i == '0);
  assign empty_evt_o = empty_now && !empty_q;
  assign hist_o      = hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_q <= 1'b1;
      hist_q  <= 1'b0;
    end else begin
      empty_q <= empty_now;
      if (empty_evt_o)                hist_q <= 1'b0;
      else if (fifo_level_i >= HeavyLvl) hist_q <= 1'b1;
    end
  end
endmodule

// File: rtl/thre_char_timer.sv
module thre_char_timer
  import thre_qual_pkg::*;
#(
  parameter int unsigned WLEN_W   = 2,
  parameter int unsigned MIN_DATA = 5,
  parameter int unsigned CNT_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              cancel_i,
  input  logic              tick_i,
  input  logic [WLEN_W-1:0] word_len_i,
  input  logic              parity_en_i,
  output logic              fire_o,
  output logic              busy_o
);
  tmr_state_e       st_q;
  logic [CNT_W-1:0] cnt_q, span;

  // start bit + data bits + parity, stop bit excluded
  assign span = CNT_W'(1 + MIN_DATA) + CNT_W'(word_len_i) + CNT_W'(parity_en_i);

  assign busy_o = (st_q == TMR_RUN);
  assign fire_o = busy_o && tick_i && (cnt_q == CNT_W'(1)) && !cancel_i && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= TMR_IDLE;
      cnt_q <= '0;
    end else if (load_i) begin
      st_q  <= TMR_RUN;
      cnt_q <= span;
    end else if (cancel_i) begin
      st_q  <= TMR_IDLE;
      cnt_q <= '0;
    end else if (busy_o && tick_i) begin
      if (cnt_q == CNT_W'(1)) begin
        st_q  <= TMR_IDLE;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/thre_irq_reg.sv
module thre_irq_reg
  import thre_qual_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_i,
  input  logic       thr_wr_i,
  input  logic       iir_rd_i,
  input  logic [2:0] iir_id_i,
  output logic       irq_o
);
  logic irq_q, clr;

  assign clr   = thr_wr_i || (iir_rd_i && (iir_id_i == IID_THRE));
  assign irq_o = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (clr)   irq_q <= 1'b0;
    else if (set_i) irq_q <= 1'b1;
  end
endmodule

// File: rtl/thre_irq_qual.sv
module thre_irq_qual #(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned HEAVY_LVL  = 2,
  parameter int unsigned WLEN_W     = 2,
  parameter int unsigned MIN_DATA   = 5,
  parameter int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LVL_W-1:0]  fifo_level_i,
  input  logic              thr_wr_i,
  input  logic              iir_rd_i,
  input  logic [2:0]        iir_id_i,
  input  logic [WLEN_W-1:0] word_len_i,
  input  logic              parity_en_i,
  input  logic              bit_tick_i,
  output logic              thre_irq_o
);
  localparam int unsigned MaxSpan = 1 + MIN_DATA + (2 ** WLEN_W - 1) + 1;
  localparam int unsigned CntW    = $clog2(MaxSpan + 1);

  logic empty_evt, hist_q, tmr_load, tmr_cancel, tmr_fire, tmr_busy, irq_set;

  thre_fifo_hist #(.LVL_W(LVL_W), .HEAVY_LVL(HEAVY_LVL)) u_hist (
    .clk_i, .rst_ni, .fifo_level_i,
    .empty_evt_o(empty_evt), .hist_o(hist_q)
  );

  assign tmr_load   = empty_evt && !hist_q && !thr_wr_i;
  assign tmr_cancel = thr_wr_i || (fifo_level_i != '0);

  thre_char_timer #(.WLEN_W(WLEN_W), .MIN_DATA(MIN_DATA), .CNT_W(CntW)) u_tmr (
    .clk_i, .rst_ni,
    .load_i(tmr_load), .cancel_i(tmr_cancel), .tick_i(bit_tick_i),
    .word_len_i, .parity_en_i,
    .fire_o(tmr_fire), .busy_o(tmr_busy)
  );

  assign irq_set = (empty_evt && hist_q) || tmr_fire;

  thre_irq_reg u_irq (
    .clk_i, .rst_ni, .set_i(irq_set),
    .thr_wr_i, .iir_rd_i, .iir_id_i,
    .irq_o(thre_irq_o)
  );
endmodule

// File: rtl/thre_irq_qual_chk.sv
module thre_irq_qual_chk #(
  parameter int unsigned LVL_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LVL_W-1:0] fifo_level_i,
  input logic             thr_wr_i,
  input logic             iir_rd_i,
  input logic [2:0]       iir_id_i,
  input logic             thre_irq_o,
  input logic             empty_evt,
  input logic             hist_q,
  input logic             tmr_busy
);
  a_r2_heavy_now: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_evt && hist_q && !thr_wr_i |=> thre_irq_o);

  a_r4_empty_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(thre_irq_o) |-> $past(fifo_level_i) == '0);

  a_r5_wr_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_wr_i |=> !thre_irq_o);

  a_r6_id_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iir_rd_i && iir_id_i == 3'b001 |=> !thre_irq_o);

  a_r7_wr_cancels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_wr_i |=> !tmr_busy);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thre_irq_o && !thr_wr_i && !(iir_rd_i && iir_id_i == 3'b001) |=> thre_irq_o);
endmodule

bind thre_irq_qual thre_irq_qual_chk #(.LVL_W(LVL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fifo_level_i(fifo_level_i),
  .thr_wr_i(thr_wr_i), .iir_rd_i(iir_rd_i), .iir_id_i(iir_id_i),
  .thre_irq_o(thre_irq_o), .empty_evt(empty_evt), .hist_q(hist_q),
  .tmr_busy(tmr_busy)
);

// File: tb/sim_thre_irq_qual.sv
module sim_thre_irq_qual;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] fifo_level_i = '0;
  logic       thr_wr_i = 1'b0;
  logic       iir_rd_i = 1'b0;
  logic [2:0] iir_id_i = 3'b000;
  logic [1:0] word_len_i = 2'd0;
  logic       parity_en_i = 1'b0;
  logic       bit_tick_i = 1'b0;
  logic       thre_irq_o;

  int  errs = 0;
  int  checks = 0;
  bit  done = 1'b0;

  always #4 clk_i = ~clk_i;

  thre_irq_qual u0 (.*);

  typedef struct packed {
    logic [1:0] wl;
    logic       par;
    logic [3:0] n;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd0, 1'b0, 4'd6},  '{2'd1, 1'b0, 4'd7},
    '{2'd2, 1'b0, 4'd8},  '{2'd3, 1'b0, 4'd9},
    '{2'd0, 1'b1, 4'd7},  '{2'd1, 1'b1, 4'd8},
    '{2'd2, 1'b1, 4'd9},  '{2'd3, 1'b1, 4'd10}
  };

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(input logic exp, input string req);
    checks++;
    if (thre_irq_o !== exp) begin
      errs++;
      $display("FAIL %s: thre_irq_o=%b expected %b at %0t", req, thre_irq_o, exp, $time);
    end
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      bit_tick_i = 1'b1; step(); bit_tick_i = 1'b0;
    end
  endtask

  // one write to level 1, then drain to 0: light use
  task automatic light_drain();
    fifo_level_i = 5'd1; thr_wr_i = 1'b1; step();
    thr_wr_i = 1'b0; step();
    fifo_level_i = 5'd0; step();
  endtask

  // two writes reach level 2, then drain
  task automatic heavy_fill();
    fifo_level_i = 5'd1; thr_wr_i = 1'b1; step();
    fifo_level_i = 5'd2; step();
    thr_wr_i = 1'b0; fifo_level_i = 5'd1; step();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    step();
    chk(1'b0, "R1 reset");

    // R3 table of frame settings, light use throughout
    for (int i = 0; i < 8; i++) begin
      word_len_i = VEC[i].wl; parity_en_i = VEC[i].par;
      light_drain();
      ticks(int'(VEC[i].n) - 1);
      chk(1'b0, "R3 before last tick");
      ticks(1);
      chk(1'b1, "R3 on last tick");
      fifo_level_i = 5'd1; thr_wr_i = 1'b1; step(); thr_wr_i = 1'b0;
      chk(1'b0, "R5 write clears");
    end

    // R2 heavy drain is immediate, R8 history cleared afterwards
    word_len_i = 2'd0; parity_en_i = 1'b0;
    heavy_fill();
    fifo_level_i = 5'd0; step();
    chk(1'b1, "R2 immediate after heavy use");
    fifo_level_i = 5'd1; thr_wr_i = 1'b1; step(); thr_wr_i = 1'b0;
    chk(1'b0, "R5 write clears");
    fifo_level_i = 5'd0; step();
    chk(1'b0, "R8 light drain after heavy is delayed");
    ticks(6);
    chk(1'b1, "R8 delayed fire");

    // R10 hold
    repeat (5) step();
    chk(1'b1, "R10 hold while idle");
    ticks(3);
    chk(1'b1, "R10 hold across ticks");

    // R6 identification read
    iir_rd_i = 1'b1; iir_id_i = 3'b010; step();
    chk(1'b1, "R6 other id ignored");
    iir_id_i = 3'b000; step();
    chk(1'b1, "R6 id 000 ignored");
    iir_id_i = 3'b001; step(); iir_rd_i = 1'b0; iir_id_i = 3'b000;
    chk(1'b0, "R6 id 001 clears");

    // R7 write during the delay cancels it
    light_drain();
    ticks(3);
    fifo_level_i = 5'd1; thr_wr_i = 1'b1; step(); thr_wr_i = 1'b0;
    ticks(12);
    chk(1'b0, "R7 cancelled delay");

    // R9 write in the same cycle as a heavy empty event
    heavy_fill();
    fifo_level_i = 5'd0; thr_wr_i = 1'b1; step();
    thr_wr_i = 1'b0; fifo_level_i = 5'd1;
    chk(1'b0, "R9 write wins over set");
    ticks(12);
    chk(1'b0, "R4 no rise while level nonzero");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule